// File: doc/BRIEF.md
# Device Command Mailbox

This block is the device side of a command mailbox that a host reaches through a small memory-mapped register window. The host places an opcode and a payload length in the command register and fills a shared payload buffer if the command has input data. It then sets the doorbell. The block holds the doorbell, passes the command to a local handler, and waits for the handler to report completion. The handler may take a single cycle or many cycles.

While the doorbell is set, the handler owns the buffer. It reads the input words and writes its output words through a private buffer port. When the handler reports completion, the block records the return code in the status register. On success it also replaces the length field of the command register with the output length. It then drops the doorbell. The host polls the doorbell and reads the results once it has cleared.

Register-bus accesses may be 32 or 64 bits wide. The window has this layout: control at byte 0x04, command at 0x08, status at 0x10, background status at 0x18, and a 256-byte payload buffer from 0x20.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the doorbell (control bit 0), the error flag (control bit 1), the status register and the background-status register all read as zero.
- R2: A host write with control bit 0 set, while the doorbell is clear, sets the doorbell. If the length fits the buffer, `hs_start` is high for exactly one cycle, in the cycle after the write is accepted, with `hs_opcode`/`hs_len` taken from the command register. The command register holds the opcode in bits 15:0 and a 21-bit length in bits 36:16, and bits 63:37 read zero.
- R3: The doorbell stays set until the handler pulses `hs_done` and clears in the following cycle. Writing 0 to control bit 0 does not clear it. Writing 1 while it is set starts no second command.
- R4: On completion the 16-bit return code appears in bits 47:32 of the 64-bit status register (byte 0x10). All other status bits read zero, and zero means success.
- R5: When the return code is zero, the command length field is replaced by `hs_out_len`. With a non-zero code the command register keeps its contents.
- R6: A length greater than 256 completes without a start pulse, with return code 0x0016. The doorbell clears in the cycle after it was first seen set.
- R7: Host writes to the command register or payload buffer while the doorbell is set are ignored and set a sticky error flag (control bit 1). Writing 1 to control bit 1 clears the flag.
- R8: The window is organised as 64-bit words. A 64-bit access uses the whole word. A 32-bit access with address bit 2 set reaches the upper half, returned in or taken from data bits 31:0. The control fields therefore sit at bits 33:32 of the word at byte 0.
- R9: Payload word i sits at byte 0x20+8*i. The handler reads input words and writes output words through its own port, and the host reads back what the handler wrote.
- R10: The status and background-status registers ignore host writes, and the background-status register always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_valid | input | 1 | Host access request |
| h_ready | output | 1 | Access accepted (always 1) |
| h_write | input | 1 | 1 = write, 0 = read |
| h_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit |
| h_addr | input | 7 | Byte address bits 8:2 in the window |
| h_wdata | input | 64 | Write data (bits 31:0 for 32-bit) |
| h_rvalid | output | 1 | Response for the access of the previous cycle |
| h_rdata | output | 64 | Read data (bits 31:0 for 32-bit) |
| hs_start | output | 1 | One-cycle command start to the handler |
| hs_opcode | output | 16 | Opcode of the pending command |
| hs_len | output | 21 | Input payload length in bytes |
| hs_done | input | 1 | Handler completion pulse |
| hs_rc | input | 16 | Return code with `hs_done` |
| hs_out_len | input | 21 | Output length with `hs_done` |
| dev_we | input | 1 | Handler payload write enable |
| dev_widx | input | 5 | Handler payload write word index |
| dev_wdata | input | 64 | Handler payload write data |
| dev_ridx | input | 5 | Handler payload read word index |
| dev_rdata | output | 64 | Handler payload read data (combinational) |

## Verification
The bench builds the block with the default buffer of 256 bytes: 32 payload words and a 9-bit window. At this size the boundary between a length of 256 (accepted) and 257 (rejected) can be hit directly, and every word of the buffer can be read back after each command. Random opcodes, lengths and handler latencies from zero to a dozen cycles are mixed with one long-latency command. That command leaves room for blocked writes, a repeated doorbell and a zero write while the doorbell is held. The bench polls continuously, so it can check the doorbell-clear cycle exactly.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
  // register layout constants (field positions are decoded by the host)
  localparam int OP_W    = 16;
  localparam int LEN_W   = 21;
  localparam int RC_W    = 16;
  localparam int LEN_LSB = 16;
  localparam int RC_LSB  = 32;
  localparam int W_CTRL  = 0;
  localparam int W_CMD   = 1;
  localparam int W_STAT  = 2;
  localparam int W_BG    = 3;
  localparam int W_PAY0  = 4;
  localparam logic [RC_W-1:0] RC_BAD_LEN = 16'h0016;

  typedef enum logic {SQ_IDLE, SQ_BUSY} sq_state_e;

  // merge a 32- or 64-bit write into a 64-bit word
  function automatic logic [63:0] lane_merge(input logic [63:0] old_w,
                                             input logic [63:0] wd,
                                             input logic wide, input logic hi);
    if (wide)    return wd;
    else if (hi) return {wd[31:0], old_w[31:0]};
    else         return {old_w[63:32], wd[31:0]};
  endfunction

  // select the returned lane of a read
  function automatic logic [63:0] lane_pick(input logic [63:0] w,
                                            input logic wide, input logic hi);
    if (wide)    return w;
    else if (hi) return {32'h0, w[63:32]};
    else         return {32'h0, w[31:0]};
  endfunction

  function automatic logic [63:0] cmd_pack(input logic [OP_W-1:0] op,
                                           input logic [LEN_W-1:0] len);
    return {{(64-LEN_LSB-LEN_W){1'b0}}, len, op};
  endfunction

  function automatic logic [63:0] stat_pack(input logic [RC_W-1:0] rc);
    return {{(64-RC_LSB-RC_W){1'b0}}, rc, {RC_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/cmb_payload_buf.sv
module cmb_payload_buf #(
  parameter int WORDS  = 32,
  parameter int IDX_W  = 5
) (
  input  logic             clk,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [63:0]      host_wdata,
  output logic [63:0]      host_rdata,
  input  logic             dev_we,
  input  logic [IDX_W-1:0] dev_widx,
  input  logic [63:0]      dev_wdata,
  input  logic [IDX_W-1:0] dev_ridx,
  output logic [63:0]      dev_rdata
);
  logic [63:0] mem [WORDS];

  // handler port wins a same-word clash; contents are not reset
  always_ff @(posedge clk) begin
    for (int w = 0; w < WORDS; w++) begin
      if (dev_we && dev_widx == IDX_W'(w))
        mem[w] <= dev_wdata;
      else if (host_we && host_idx == IDX_W'(w))
        mem[w] <= host_wdata;
    end
  end

  assign host_rdata = mem[host_idx];
  assign dev_rdata  = mem[dev_ridx];
endmodule

// File: rtl/cmb_sequencer.sv
module cmb_sequencer import cmb_pkg::*; #(
  parameter int PAY_BYTES = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             hs_done,
  input  logic [RC_W-1:0]  hs_rc,
  input  logic [LEN_W-1:0] hs_out_len,
  output logic             doorbell,
  output logic             hs_start,
  output logic [RC_W-1:0]  stat_rc,
  output logic             len_upd,
  output logic [LEN_W-1:0] len_val
);
  sq_state_e state_q;
  logic      len_ok;
  logic      finish_evt;
  logic      bad_len_evt;

  assign len_ok      = {{(32-LEN_W){1'b0}}, cmd_len} <= 32'(PAY_BYTES);
  assign finish_evt  = (state_q == SQ_BUSY) && hs_done;
  assign bad_len_evt = (state_q == SQ_IDLE) && doorbell && !len_ok;
  assign hs_start    = (state_q == SQ_IDLE) && doorbell && len_ok;
  assign len_upd     = finish_evt && (hs_rc == '0);
  assign len_val     = hs_out_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      doorbell <= 1'b0;
      stat_rc  <= '0;
    end else begin
      if (ring && !doorbell) doorbell <= 1'b1;
      if (hs_start) state_q <= SQ_BUSY;
      if (finish_evt) begin
        state_q  <= SQ_IDLE;
        doorbell <= 1'b0;
        stat_rc  <= hs_rc;
      end
      if (bad_len_evt) begin
        doorbell <= 1'b0;
        stat_rc  <= RC_BAD_LEN;
      end
    end
  end

  a_r3_db_fall_needs_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(doorbell) |-> $past(finish_evt || bad_len_evt));
  a_r3_clear_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> !doorbell);
  a_r2_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    hs_start |=> !hs_start);
  a_r2_ring_leads_on: assert property (@(posedge clk) disable iff (!rst_n)
    (ring && !doorbell) |=> (hs_start || bad_len_evt));
  a_r3_ring_while_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ring && doorbell && !finish_evt && !bad_len_evt) |=> (doorbell && !hs_start));
  a_r6_bad_len_code: assert property (@(posedge clk) disable iff (!rst_n)
    bad_len_evt |=> (stat_rc == RC_BAD_LEN && !doorbell));
  a_r4_rc_captured: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> (stat_rc == $past(hs_rc)));
endmodule

// File: rtl/cmb_host_port.sv
module cmb_host_port import cmb_pkg::*; #(
  parameter int ADDR_W = 9,
  parameter int WORDS  = 32,
  parameter int PIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_valid,
  input  logic              h_write,
  input  logic              h_wide,
  input  logic [ADDR_W-1:2] h_addr,
  input  logic [63:0]       ctrl_word,
  input  logic [63:0]       cmd_word,
  input  logic [63:0]       stat_word,
  input  logic [63:0]       pay_word,
  output logic [PIDX_W-1:0] pay_idx,
  output logic              hi,
  output logic              wr_ctrl,
  output logic              wr_cmd,
  output logic              wr_pay,
  output logic              h_rvalid,
  output logic [63:0]       h_rdata
);
  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] idx;
  logic             is_pay;
  logic             wr;
  logic [63:0]      rd_word;

  assign idx     = h_addr[ADDR_W-1:3];
  assign hi      = h_addr[2];
  assign is_pay  = int'(idx) >= W_PAY0 && int'(idx) < W_PAY0 + WORDS;
  assign pay_idx = PIDX_W'(idx - IDX_W'(W_PAY0));
  assign wr      = h_valid && h_write;
  assign wr_ctrl = wr && idx == IDX_W'(W_CTRL) && (h_wide || hi);
  assign wr_cmd  = wr && idx == IDX_W'(W_CMD);
  assign wr_pay  = wr && is_pay;

  always_comb begin
    rd_word = '0;
    if (is_pay) rd_word = pay_word;
    else if (idx == IDX_W'(W_CTRL)) rd_word = ctrl_word;
    else if (idx == IDX_W'(W_CMD))  rd_word = cmd_word;
    else if (idx == IDX_W'(W_STAT)) rd_word = stat_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_rvalid <= 1'b0;
      h_rdata  <= '0;
    end else begin
      h_rvalid <= h_valid;
      if (h_valid && !h_write) h_rdata <= lane_pick(rd_word, h_wide, hi);
    end
  end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox import cmb_pkg::*; #(
  parameter  int PAY_BYTES = 256,
  localparam int WORDS  = PAY_BYTES / 8,
  localparam int PIDX_W = $clog2(WORDS),
  localparam int ADDR_W = $clog2(8 * W_PAY0 + PAY_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_valid,
  output logic              h_ready,
  input  logic              h_write,
  input  logic              h_wide,
  input  logic [ADDR_W-1:2] h_addr,
  input  logic [63:0]       h_wdata,
  output logic              h_rvalid,
  output logic [63:0]       h_rdata,
  output logic              hs_start,
  output logic [OP_W-1:0]   hs_opcode,
  output logic [LEN_W-1:0]  hs_len,
  input  logic              hs_done,
  input  logic [RC_W-1:0]   hs_rc,
  input  logic [LEN_W-1:0]  hs_out_len,
  input  logic              dev_we,
  input  logic [PIDX_W-1:0] dev_widx,
  input  logic [63:0]       dev_wdata,
  input  logic [PIDX_W-1:0] dev_ridx,
  output logic [63:0]       dev_rdata
);
  localparam logic [63:0] CMD_MASK = cmd_pack('1, '1);

  logic [63:0]       cmd_q;
  logic              err_q;
  logic              doorbell;
  logic [RC_W-1:0]   stat_rc;
  logic              len_upd;
  logic [LEN_W-1:0]  len_val;
  logic [PIDX_W-1:0] pay_idx;
  logic              hi;
  logic              wr_ctrl, wr_cmd, wr_pay;
  logic [63:0]       pay_word;
  logic [1:0]        ctrl_bits;
  logic              ring;
  logic              blocked_evt;
  logic              host_we;
  logic [63:0]       ctrl_word;

  assign h_ready     = 1'b1;
  assign ctrl_bits   = h_wide ? h_wdata[33:32] : h_wdata[1:0];
  assign ring        = wr_ctrl && ctrl_bits[0];
  assign blocked_evt = (wr_cmd || wr_pay) && doorbell;
  assign host_we     = wr_pay && !doorbell;
  assign ctrl_word   = {30'h0, err_q, doorbell, 32'h0};
  assign hs_opcode   = cmd_q[OP_W-1:0];
  assign hs_len      = cmd_q[LEN_LSB +: LEN_W];

  cmb_host_port #(.ADDR_W(ADDR_W), .WORDS(WORDS), .PIDX_W(PIDX_W)) u_port (
    .clk, .rst_n, .h_valid, .h_write, .h_wide, .h_addr,
    .ctrl_word, .cmd_word(cmd_q), .stat_word(stat_pack(stat_rc)), .pay_word,
    .pay_idx, .hi, .wr_ctrl, .wr_cmd, .wr_pay, .h_rvalid, .h_rdata
  );

  cmb_sequencer #(.PAY_BYTES(PAY_BYTES)) u_seq (
    .clk, .rst_n, .ring, .cmd_len(hs_len), .hs_done, .hs_rc, .hs_out_len,
    .doorbell, .hs_start, .stat_rc, .len_upd, .len_val
  );

  cmb_payload_buf #(.WORDS(WORDS), .IDX_W(PIDX_W)) u_buf (
    .clk, .host_we, .host_idx(pay_idx),
    .host_wdata(lane_merge(pay_word, h_wdata, h_wide, hi)),
    .host_rdata(pay_word), .dev_we, .dev_widx, .dev_wdata, .dev_ridx, .dev_rdata
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (len_upd)
        cmd_q[LEN_LSB +: LEN_W] <= len_val;
      else if (wr_cmd && !doorbell)
        cmd_q <= lane_merge(cmd_q, h_wdata, h_wide, hi) & CMD_MASK;
      if (blocked_evt)
        err_q <= 1'b1;
      else if (wr_ctrl && ctrl_bits[1])
        err_q <= 1'b0;
    end
  end

  a_r7_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && doorbell && !len_upd) |=> $stable(cmd_q));
  a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(blocked_evt));
  a_r5_len_written: assert property (@(posedge clk) disable iff (!rst_n)
    len_upd |=> (cmd_q[LEN_LSB +: LEN_W] == $past(len_val)));
  a_r9_no_port_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_we && dev_we));
endmodule

// File: tb/cmd_mailbox_tb.sv
module cmd_mailbox_tb;
  localparam int WORDS = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, h_valid, h_ready, h_write, h_wide, h_rvalid;
  logic [8:2]  h_addr;
  logic [63:0] h_wdata, h_rdata;
  logic        hs_start, hs_done, dev_we;
  logic [15:0] hs_opcode, hs_rc;
  logic [20:0] hs_len, hs_out_len;
  logic [4:0]  dev_widx, dev_ridx;
  logic [63:0] dev_wdata, dev_rdata;

  cmd_mailbox u_dut (.*);

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [63:0] mdl [WORDS];
  int unsigned last_wr_cyc;
  int forced_lat = -1;
  int n_start = 0;
  int unsigned start_cyc, done_cyc;
  logic [15:0] st_op;
  logic [20:0] st_len;
  logic [63:0] last_stat = 64'h0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] f_xform(input logic [63:0] d, input logic [15:0] op);
    return {d[31:0], d[63:32]} ^ {48'h0, op};
  endfunction
  function automatic int f_words(input logic [20:0] len);
    return (int'(len) + 7) / 8;
  endfunction
  function automatic logic [20:0] f_out_len(input logic [20:0] len);
    return (len > 21'd8) ? len - 21'd8 : len;
  endfunction
  function automatic logic [15:0] f_rc(input logic [15:0] op);
    return op[15] ? ({8'h0, op[7:0]} | 16'h1) : 16'h0;
  endfunction

  // handler model: echoes a transformed payload after a latency
  initial begin
    hs_done = 0; hs_rc = 0; hs_out_len = 0;
    dev_we = 0; dev_widx = 0; dev_wdata = 0; dev_ridx = 0;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && hs_start === 1'b1) begin
        int lat;
        n_start++; start_cyc = cyc; st_op = hs_opcode; st_len = hs_len;
        lat = (forced_lat >= 0) ? forced_lat : int'($urandom_range(0, 12));
        @(negedge clk);
        repeat (lat) @(negedge clk);
        if (f_rc(st_op) == 16'h0) begin
          for (int i = 0; i < f_words(st_len); i++) begin
            dev_ridx = 5'(i);
            #1;
            dev_wdata = f_xform(dev_rdata, st_op);
            dev_widx = 5'(i);
            dev_we = 1;
            @(negedge clk);
            dev_we = 0;
          end
        end
        hs_done = 1; hs_rc = f_rc(st_op); hs_out_len = f_out_len(st_len); done_cyc = cyc;
        @(negedge clk);
        hs_done = 0;
      end
    end
  end

  task automatic bwr(input logic [8:0] a, input logic [63:0] d, input bit wide);
    h_valid = 1; h_write = 1; h_wide = wide; h_addr = a[8:2]; h_wdata = d;
    last_wr_cyc = cyc;
    @(negedge clk);
    h_valid = 0; h_write = 0;
  endtask

  task automatic brd(input logic [8:0] a, input bit wide, output logic [63:0] d);
    h_valid = 1; h_write = 0; h_wide = wide; h_addr = a[8:2];
    @(negedge clk);
    h_valid = 0;
    d = h_rdata;
  endtask

  task automatic poll(output int unsigned zc);
    logic [63:0] d;
    zc = 0;
    for (int k = 0; k < 600; k++) begin
      brd(9'h004, 0, d);
      if (!d[0]) begin zc = cyc; break; end
    end
  endtask

  task automatic check_buffer(input string tag);
    logic [63:0] d;
    for (int i = 0; i < WORDS; i++) begin
      brd(9'(32 + 8 * i), 1, d);
      chk(d === mdl[i], tag, d, mdl[i]);
    end
  endtask

  task automatic run_cmd(input logic [15:0] op, input logic [20:0] len, input int nwr);
    logic [63:0] d, exp_cmd;
    logic [15:0] exp_rc;
    int unsigned ring_cyc, zc;
    int s0;
    bit fits;
    for (int i = 0; i < nwr; i++) begin
      d = {$urandom, $urandom};
      bwr(9'(32 + 8 * i), d, 1);
      mdl[i] = d;
    end
    bwr(9'h008, {27'h0, len, op}, 1);
    s0 = n_start;
    bwr(9'h004, 64'h1, 0);
    ring_cyc = last_wr_cyc;
    poll(zc);
    fits = (len <= 21'd256);
    exp_rc = fits ? f_rc(op) : 16'h0016;
    if (fits) begin
      chk(n_start == s0 + 1, "R2 one start pulse", 64'(n_start - s0), 64'd1);
      chk(start_cyc == ring_cyc + 1, "R2 start cycle", 64'(start_cyc - ring_cyc), 64'd1);
      chk(st_op == op && st_len == len, "R2 opcode/length", {st_len, st_op}, {len, op});
      chk(zc == done_cyc + 2, "R3 doorbell clears after done", 64'(zc - done_cyc), 64'd2);
    end else begin
      chk(n_start == s0, "R6 no start on bad length", 64'(n_start - s0), 64'd0);
      chk(zc == ring_cyc + 3, "R6 doorbell clear timing", 64'(zc - ring_cyc), 64'd3);
    end
    brd(9'h010, 1, d);
    last_stat = {16'h0, exp_rc, 32'h0};
    chk(d === last_stat, fits ? "R4 status code" : "R6 bad length code", d, last_stat);
    exp_cmd = {27'h0, (fits && exp_rc == 16'h0) ? f_out_len(len) : len, op};
    brd(9'h008, 1, d);
    chk(d === exp_cmd, "R5 command length write-back", d, exp_cmd);
    if (fits && exp_rc == 16'h0)
      for (int i = 0; i < f_words(len); i++) mdl[i] = f_xform(mdl[i], op);
    check_buffer("R9 payload contents");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] d, e;
    int s0;
    int unsigned zc;
    void'($urandom(32'h5eed));
    rst_n = 0; h_valid = 0; h_write = 0; h_wide = 0; h_addr = '0; h_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    brd(9'h000, 1, d); chk(d === 64'h0, "R1 control after reset", d, 64'h0);
    brd(9'h010, 1, d); chk(d === 64'h0, "R1 status after reset", d, 64'h0);
    brd(9'h018, 1, d); chk(d === 64'h0, "R1 background after reset", d, 64'h0);

    for (int i = 0; i < WORDS; i++) begin
      d = {$urandom, $urandom};
      bwr(9'(32 + 8 * i), d, 1);
      mdl[i] = d;
    end
    check_buffer("R9 host write/read");

    // R8 32-bit lanes
    bwr(9'h008, 64'hABCD_0040_0055, 0);
    bwr(9'h00C, 64'hFFFF_FFE0, 0);
    brd(9'h008, 1, d); e = {27'h0, 21'h40, 16'h0055};
    chk(d === e, "R8 command via two 32-bit writes", d, e);
    brd(9'h00C, 0, d); chk(d === 64'h0, "R8 upper command half", d, 64'h0);
    bwr(9'(32 + 8 * 5 + 4), 64'h1234_5678, 0);
    mdl[5] = {32'h1234_5678, mdl[5][31:0]};
    brd(9'(32 + 8 * 5), 1, d); chk(d === mdl[5], "R8 32-bit payload upper lane", d, mdl[5]);
    brd(9'(32 + 8 * 5), 0, d); e = {32'h0, mdl[5][31:0]};
    chk(d === e, "R8 32-bit payload lower lane", d, e);

    // directed corners
    run_cmd(16'h0001, 21'd0, 0);
    run_cmd(16'h0002, 21'd256, 2);
    run_cmd(16'h0003, 21'd257, 1);
    run_cmd(16'h8042, 21'd16, 2);
    run_cmd(16'h0004, 21'd8, 1);

    // R7 blocked writes during a long command
    forced_lat = 40;
    bwr(9'h008, {27'h0, 21'd24, 16'h0123}, 1);
    s0 = n_start;
    bwr(9'h004, 64'h1, 0);
    bwr(9'h008, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    bwr(9'(32 + 8 * 31), 64'hDEAD_BEEF_0BAD_F00D, 1);
    bwr(9'h004, 64'h1, 0);
    bwr(9'h004, 64'h0, 0);
    brd(9'h004, 0, d); chk(d[1:0] == 2'b11, "R7 error flag and R3 doorbell held", 64'(d[1:0]), 64'd3);
    brd(9'h000, 1, d); chk(d === 64'h3_0000_0000, "R8 control at bits 33:32", d, 64'h3_0000_0000);
    chk(n_start == s0 + 1, "R3 no second start", 64'(n_start - s0), 64'd1);
    poll(zc);
    forced_lat = -1;
    chk(zc == done_cyc + 2, "R3 clear after long command", 64'(zc - done_cyc), 64'd2);
    brd(9'h008, 1, d); e = {27'h0, 21'd16, 16'h0123};
    chk(d === e, "R7 command write ignored", d, e);
    for (int i = 0; i < 3; i++) mdl[i] = f_xform(mdl[i], 16'h0123);
    check_buffer("R7 payload write ignored");
    brd(9'h004, 0, d); chk(d[1] == 1'b1, "R7 error flag sticky", 64'(d[1]), 64'd1);
    bwr(9'h004, 64'h2, 0);
    brd(9'h004, 0, d); chk(d === 64'h0, "R7 error flag cleared", d, 64'h0);
    last_stat = 64'h0;

    // random commands
    for (int k = 0; k < 20; k++) begin
      logic [20:0] len;
      len = (k % 5 == 0) ? 21'(257 + $urandom_range(0, 500)) : 21'($urandom_range(0, 256));
      run_cmd(16'($urandom), len, int'($urandom_range(0, 4)));
    end

    // R10 read-only registers
    bwr(9'h010, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    bwr(9'h018, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    brd(9'h010, 1, d); chk(d === last_stat, "R10 status ignores writes", d, last_stat);
    brd(9'h018, 1, d); chk(d === 64'h0, "R10 background reads zero", d, 64'h0);
    brd(9'h01C, 0, d); chk(d === 64'h0, "R10 background upper half", d, 64'h0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule